// File: doc/BRIEF.md
# GPIO Companion Register Block

This block is a small peripheral that sits on a simple synchronous register bus. It holds sixteen general-purpose I/O lines and a set of 16-bit holding registers for mode, clock divide, clock control, power, status and interrupt bookkeeping. A host reaches the registers by placing an address, a write enable and write data on the bus. Read data comes back one cycle after the address is presented.

The GPIO section has a direction register and a level register. A line is driven only where its direction bit selects output: the driven vector is the level ANDed with the direction. The driven vector is re-evaluated whenever the host writes either register. When that happens, every line whose driven value changed raises a one-cycle change strobe. Board logic can also push input values into the level register, one line at a time. This updates the stored bit but does not touch the driven vector until the next host write to direction or level.

The block answers only inside a 4 KB window that starts at a parameterised base address. Offsets inside the window that are not used read as zero, and writes to them are dropped.

Top module: `gpio_companion`

## Requirements
- R1: After a synchronous reset, the status register (offset 0x08) reads 0x0002, and every other register reads 0x0000. After the same reset, `gpio_out` and `chg_valid` are zero.
- R2: The block responds only to addresses from BASE_ADDR to BASE_ADDR+0xFFF.
    - The used offsets are 0x00 mode, 0x04 clock divide, 0x08 status, 0x0C power, 0x10 clock control, 0x14 raw interrupt, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level and 0x28 readback.
    - A read of any other offset, or of any address outside the window, returns 0.
    - A write to any other offset or outside the window changes no register.
- R3: Only bits 15:0 of the write data are stored. The upper bits are discarded.
- R4: Writing the power register (0x0C) with bit 7 set stores the data ORed with 0x8040. With bit 7 clear, the data is stored unchanged.
- R5: A host write to the level register (0x24) stores the data ANDed with the direction register's value before that write.
- R6: `gpio_out` equals level AND direction, as computed at the clock edge that accepts a host write to direction (0x20) or level (0x24). `gpio_out` holds its value at all other times.
- R7: In the cycle after such a write, `chg_valid[n]` is 1 exactly for the lines whose `gpio_out` value changed. In every other cycle, `chg_valid` is zero.
- R8: When `ext_valid[n]` is 1, bit n of the level register takes `ext_level[n]`. Lines with `ext_valid[n]` at 0 keep their level bit. An external update alone leaves `gpio_out` and `chg_valid` unchanged.
- R9: When a host level write and an external update fall in the same cycle, the level register takes the host write value on every bit.
- R10: The status register is read-only. Writes to offset 0x08 leave it at 0x0002.
- R11: `bus_rdata` shows the register addressed in the previous cycle, taken from that register's value before the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address on the register bus |
| bus_wr | input | 1 | Write enable for the current address |
| bus_wdata | input | BUS_W | Write data; only the low 16 bits are kept |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| ext_valid | input | 16 | Per-line enable for an external level update |
| ext_level | input | 16 | Per-line value written when the enable is set |
| gpio_out | output | 16 | Driven output vector (level AND direction) |
| chg_valid | output | 16 | One-cycle per-line strobe when a driven value changes |

## Verification
The embedded properties rely on two assumptions about the inputs. First, the bus carries at most one write per cycle. Second, during reset `bus_wr` stays low, so no access is in flight when reset releases. The stimulus holds to both: it changes every input on the falling clock edge and keeps `bus_wr` low for the whole reset interval. The stimulus also deliberately lines up external line updates with host level and direction writes in the same cycle, so the priority and merge rules are exercised under the same conditions the properties assume.

// File: rtl/gcomp_pkg.sv
package gcomp_pkg;

    localparam int REG_W    = 16;
    localparam int NLINES   = 16;
    localparam int WIN_BITS = 12;

    localparam logic [REG_W-1:0] STAT_RESET = 16'h0002;
    localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
    localparam int               PWR_TRIG   = 7;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_CDIV,
        SEL_STAT,
        SEL_PWR,
        SEL_CCTL,
        SEL_IRAW,
        SEL_IMSK,
        SEL_ISTAT,
        SEL_DIR,
        SEL_LVL,
        SEL_RDBK
    } sel_e;

    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] cdiv;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] pwr;
        logic [REG_W-1:0] cctl;
        logic [REG_W-1:0] iraw;
        logic [REG_W-1:0] imsk;
        logic [REG_W-1:0] istat;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] lvl;
        logic [REG_W-1:0] rdbk;
    } regs_t;

    function automatic sel_e offset_to_sel(input logic [WIN_BITS-1:0] off);
        sel_e s;
        case (off)
            12'h000: s = SEL_MODE;
            12'h004: s = SEL_CDIV;
            12'h008: s = SEL_STAT;
            12'h00C: s = SEL_PWR;
            12'h010: s = SEL_CCTL;
            12'h014: s = SEL_IRAW;
            12'h018: s = SEL_IMSK;
            12'h01C: s = SEL_ISTAT;
            12'h020: s = SEL_DIR;
            12'h024: s = SEL_LVL;
            12'h028: s = SEL_RDBK;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [REG_W-1:0] power_fix(input logic [REG_W-1:0] v);
        return v[PWR_TRIG] ? (v | PWR_FORCE) : v;
    endfunction

    function automatic logic [REG_W-1:0] read_mux(input sel_e s, input regs_t r);
        logic [REG_W-1:0] d;
        case (s)
            SEL_MODE:  d = r.mode;
            SEL_CDIV:  d = r.cdiv;
            SEL_STAT:  d = r.stat;
            SEL_PWR:   d = r.pwr;
            SEL_CCTL:  d = r.cctl;
            SEL_IRAW:  d = r.iraw;
            SEL_IMSK:  d = r.imsk;
            SEL_ISTAT: d = r.istat;
            SEL_DIR:   d = r.dir;
            SEL_LVL:   d = r.lvl;
            SEL_RDBK:  d = r.rdbk;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gcomp_decode.sv
module gcomp_decode
    import gcomp_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output sel_e              sel
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] tag_in;
    logic [TAG_W-1:0] tag_base;

    assign tag_in   = addr[ADDR_W-1:WIN_BITS];
    assign tag_base = BASE_ADDR[ADDR_W-1:WIN_BITS];

    always_comb begin
        hit = (tag_in == tag_base);
        sel = hit ? offset_to_sel(addr[WIN_BITS-1:0]) : SEL_NONE;
    end
endmodule

// File: rtl/gcomp_regs.sv
module gcomp_regs
    import gcomp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_e              sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NLINES-1:0] ext_valid,
    input  logic [NLINES-1:0] ext_level,
    output regs_t             r,
    output logic              eval,
    output logic [NLINES-1:0] eff_next
);
    logic [NLINES-1:0] lvl_ext;
    logic [REG_W-1:0]  lvl_d;
    logic [REG_W-1:0]  dir_d;
    logic              wr_lvl;
    logic              wr_dir;

    // per-line external merge
    for (genvar i = 0; i < NLINES; i++) begin : g_ext
        assign lvl_ext[i] = ext_valid[i] ? ext_level[i] : r.lvl[i];
    end

    always_comb begin
        wr_lvl   = wr_en && (sel == SEL_LVL);
        wr_dir   = wr_en && (sel == SEL_DIR);
        // host write wins over external updates
        lvl_d    = wr_lvl ? (wdata & r.dir) : lvl_ext;
        dir_d    = wr_dir ? wdata : r.dir;
        eval     = wr_lvl || wr_dir;
        eff_next = lvl_d & dir_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r      <= '0;
            r.stat <= STAT_RESET;
        end else begin
            r.lvl <= lvl_d;
            r.dir <= dir_d;
            if (wr_en) begin
                case (sel)
                    SEL_MODE:  r.mode  <= wdata;
                    SEL_CDIV:  r.cdiv  <= wdata;
                    SEL_PWR:   r.pwr   <= power_fix(wdata);
                    SEL_CCTL:  r.cctl  <= wdata;
                    SEL_IRAW:  r.iraw  <= wdata;
                    SEL_IMSK:  r.imsk  <= wdata;
                    SEL_ISTAT: r.istat <= wdata;
                    SEL_RDBK:  r.rdbk  <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    // R5: stored level never has bits outside the prior direction
    p_lvl_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_LVL) |=> ((r.lvl & ~$past(r.dir)) == '0));

    // R4: bit 7 in the data forces bits 15 and 6
    p_pwr_force_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_PWR && wdata[PWR_TRIG]) |=> (r.pwr[15] && r.pwr[6]));

    // R10: status unaffected by writes
    p_stat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_STAT) |=> $stable(r.stat));
endmodule

// File: rtl/gcomp_outstage.sv
module gcomp_outstage
    import gcomp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eval,
    input  logic [NLINES-1:0] eff_next,
    output logic [NLINES-1:0] gpio_out,
    output logic [NLINES-1:0] chg_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gpio_out  <= '0;
            chg_valid <= '0;
        end else begin
            chg_valid <= eval ? (eff_next ^ gpio_out) : '0;
            if (eval) begin
                gpio_out <= eff_next;
            end
        end
    end

    // R7: strobes mark exactly the lines that moved on the last edge
    p_chg_diff_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chg_valid == (gpio_out ^ $past(gpio_out))));
endmodule

// File: rtl/gpio_companion.sv
module gpio_companion
    import gcomp_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                BUS_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       ext_valid,
    input  logic [15:0]       ext_level,
    output logic [15:0]       gpio_out,
    output logic [15:0]       chg_valid
);
    logic              hit;
    sel_e              sel;
    regs_t             regs;
    logic              eval;
    logic [NLINES-1:0] eff_next;
    logic [REG_W-1:0]  wdata16;
    logic              unused_wdata_hi;

    // R3: truncate to register width
    assign wdata16         = bus_wdata[REG_W-1:0];
    assign unused_wdata_hi = ^bus_wdata;

    gcomp_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    gcomp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .sel       (sel),
        .wdata     (wdata16),
        .ext_valid (ext_valid),
        .ext_level (ext_level),
        .r         (regs),
        .eval      (eval),
        .eff_next  (eff_next)
    );

    gcomp_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .eval      (eval),
        .eff_next  (eff_next),
        .gpio_out  (gpio_out),
        .chg_valid (chg_valid)
    );

    // R11: one registered read stage
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= read_mux(sel, regs);
        end
    end

    // R6: nothing driven on a line configured as input
    p_out_masked_r6: assert property (@(posedge clk) disable iff (rst)
        ((gpio_out & ~regs.dir) == '0));

    // R2: misses return zero
    p_rd_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit)) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_companion.sv
`timescale 1ns/1ps
module sim_gpio_companion;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [15:0] ext_valid = '0;
    logic [15:0] ext_level = '0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_out;
    logic [15:0] chg_valid;

    gpio_companion #(.ADDR_W(32), .BUS_W(32), .BASE_ADDR(BASE)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_valid (ext_valid),
        .ext_level (ext_level),
        .gpio_out  (gpio_out),
        .chg_valid (chg_valid)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          offs[11] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28};
    logic [15:0] mreg[int];
    logic [15:0] m_out = '0;
    logic [15:0] m_chg = '0;
    logic [15:0] m_rd  = '0;

    function automatic void model_reset();
        mreg.delete();
        foreach (offs[k]) mreg[offs[k]] = 16'h0000;
        mreg['h08] = 16'h0002;
        m_out = '0;
        m_chg = '0;
        m_rd  = '0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        logic [31:0] off;
        bit          win;
        int          o;
        logic [15:0] d;
        logic [15:0] eff;
        if (rst) begin
            model_reset();
        end else begin
            off = bus_addr - BASE;
            win = (off < 32'd4096);
            o   = int'(off);
            m_rd = (win && mreg.exists(o)) ? mreg[o] : 16'h0000;
            for (int i = 0; i < 16; i++)
                if (ext_valid[i]) mreg['h24][i] = ext_level[i];
            m_chg = '0;
            if (bus_wr && win && mreg.exists(o) && o != 'h08) begin
                d = bus_wdata[15:0];
                if (o == 'h0C)      mreg[o] = d[7] ? (d | 16'h8040) : d;
                else if (o == 'h24) mreg[o] = d & mreg['h20];
                else                mreg[o] = d;
                if (o == 'h20 || o == 'h24) begin
                    eff   = mreg['h24] & mreg['h20];
                    m_chg = eff ^ m_out;
                    m_out = eff;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_tag, "gpio_out", {16'h0, gpio_out}, {16'h0, m_out});
            chk(cur_tag, "chg_valid", {16'h0, chg_valid}, {16'h0, m_chg});
            chk(cur_tag, "bus_rdata", {16'h0, bus_rdata}, {16'h0, m_rd});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input string tag, input logic [31:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        chk(tag, "read", {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(120000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        cur_tag = "R1";
        @(negedge clk);
        chk("R1", "gpio_out", {16'h0, gpio_out}, 32'h0);
        chk("R1", "chg_valid", {16'h0, chg_valid}, 32'h0);
        foreach (offs[k])
            rd_expect("R1", BASE + offs[k], (offs[k] == 'h08) ? 16'h0002 : 16'h0000);

        // R2 window and unknown offsets
        cur_tag = "R2";
        wr(BASE + 32'h1020, 32'h0000_FFFF);
        wr(BASE - 32'h0FE0, 32'h0000_FFFF);
        wr(BASE + 32'h0100, 32'h0000_5555);
        rd_expect("R2", BASE + 32'h20, 16'h0000);
        rd_expect("R2", BASE + 32'h0100, 16'h0000);
        rd_expect("R2", BASE + 32'h1008, 16'h0000);
        rd_expect("R2", BASE + 32'h0001, 16'h0000);

        // R3 truncation
        cur_tag = "R3";
        wr(BASE + 32'h00, 32'hABCD_1234);
        rd_expect("R3", BASE + 32'h00, 16'h1234);

        // R4 power side effect
        cur_tag = "R4";
        wr(BASE + 32'h0C, 32'h0000_0081);
        rd_expect("R4", BASE + 32'h0C, 16'h80C1);
        wr(BASE + 32'h0C, 32'h0000_0001);
        rd_expect("R4", BASE + 32'h0C, 16'h0001);

        // R10 read-only status
        cur_tag = "R10";
        wr(BASE + 32'h08, 32'h0000_FFFF);
        rd_expect("R10", BASE + 32'h08, 16'h0002);

        // R5 level masked by direction, R6/R7 outputs and strobes
        cur_tag = "R5";
        wr(BASE + 32'h20, 32'h0000_00FF);
        chk("R7", "chg after dir", {16'h0, chg_valid}, 32'h0);
        wr(BASE + 32'h24, 32'h0000_FFFF);
        chk("R6", "gpio_out", {16'h0, gpio_out}, 32'h00FF);
        chk("R7", "chg after lvl", {16'h0, chg_valid}, 32'h00FF);
        rd_expect("R5", BASE + 32'h24, 16'h00FF);
        cur_tag = "R6";
        wr(BASE + 32'h20, 32'h0000_0F0F);
        chk("R6", "gpio_out", {16'h0, gpio_out}, 32'h000F);
        chk("R7", "chg strobe", {16'h0, chg_valid}, 32'h00F0);
        @(negedge clk);
        chk("R7", "strobe one cycle", {16'h0, chg_valid}, 32'h0);

        // R8 external updates do not re-evaluate outputs
        cur_tag = "R8";
        @(negedge clk);
        ext_valid = 16'hF000; ext_level = 16'hF0F0;
        @(negedge clk);
        ext_valid = '0;
        chk("R8", "gpio_out held", {16'h0, gpio_out}, 32'h000F);
        chk("R8", "no strobe", {16'h0, chg_valid}, 32'h0);
        rd_expect("R8", BASE + 32'h24, 16'hF0FF);
        wr(BASE + 32'h20, 32'h0000_FFFF);
        chk("R8", "gpio_out after dir", {16'h0, gpio_out}, 32'hF0FF);

        // R9 host write beats external update
        cur_tag = "R9";
        @(negedge clk);
        bus_addr = BASE + 32'h24; bus_wdata = 32'h0000_1234; bus_wr = 1'b1;
        ext_valid = 16'hFFFF; ext_level = 16'hEDCB;
        @(negedge clk);
        bus_wr = 1'b0; ext_valid = '0;
        chk("R9", "gpio_out", {16'h0, gpio_out}, 32'h1234);
        rd_expect("R9", BASE + 32'h24, 16'h1234);

        // R11 latency: address change shows on next cycle only
        cur_tag = "R11";
        @(negedge clk);
        bus_addr = BASE + 32'h00;
        @(negedge clk);
        bus_addr = BASE + 32'h24;
        chk("R11", "first", {16'h0, bus_rdata}, 32'h1234);
        @(negedge clk);
        chk("R11", "second", {16'h0, bus_rdata}, 32'h1234);

        // mixed traffic against the model
        cur_tag = "R6";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            bus_wr    = ($urandom_range(0, 1) == 1);
            bus_addr  = ($urandom_range(0, 9) == 0) ? (BASE + $urandom_range(0, 8191))
                                                    : (BASE + offs[$urandom_range(0, 10)]);
            bus_wdata = $urandom;
            ext_valid = ($urandom_range(0, 2) == 0) ? 16'($urandom) : 16'h0;
            ext_level = 16'($urandom);
        end
        @(negedge clk);
        bus_wr = 1'b0; ext_valid = '0;
        repeat (3) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end
endmodule